// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block joins three result producers of an out-of-order floating-point cluster onto a single broadcast bus. Each broadcast carries a 4-bit producer tag together with a data word, and every consumer that waits on an operand compares the tag against its own pending tag and captures the data on a match. Only one result can travel on the bus per cycle.

The producers are a group of load-data buffers, a pipelined adder with a two-cycle latency, and a shared multiply/divide unit. A multiply takes three cycles and a divide takes twelve. The arithmetic is reduced to integer operations with the correct latency. The arbiter picks a winner in every cycle by fixed priority: load buffers first, then multiply/divide, then the adder. A producer that loses keeps its result and requests again. When a unit's output is held, the unit stops taking new work, so the stall reaches the issue logic through its ready signal.

Top module: `rb_top`

## Requirements
- R1: Out of reset, `bus_valid` is 0, `bus_tag` is 0, `ld_busy` is all zeros, and both `add_in_ready` and `md_in_ready` are 1.
- R2: Setting `ld_fill[i]` on an empty buffer i stores slice i of `ld_fill_data`. With no contention, that buffer broadcasts one cycle after the fill edge with tag i+1. When several buffers are full, the lowest index is broadcast first.
- R3: An add accepted at edge k is broadcast at edge k+2 when uncontested. It carries the issued tag and (a+b) mod 2^32.
- R4: A multiply (`md_in_div`=0) accepted at edge k is broadcast at edge k+3 when uncontested. It carries the issued tag and the low 32 bits of a*b.
- R5: A divide (`md_in_div`=1) accepted at edge k is broadcast at edge k+12 when uncontested. It carries the unsigned quotient a/b, or all ones when b is 0.
- R6: At most one result is broadcast per cycle. Among pending requests the bus goes to the load group first, then multiply/divide, then the adder.
- R7: A producer that is not granted keeps its tag and data unchanged and broadcasts them later, exactly once.
- R8: `md_in_ready` is 0 while an operation is in flight or its result waits for the bus. `add_in_ready` is 0 when both adder stages hold results and the adder is not granted.
- R9: In a cycle with no broadcast, `bus_valid`, `bus_tag` and `bus_data` are all 0.
- R10: A fill aimed at a buffer that is already full is ignored. The buffer keeps its earlier data.
- R11: A cycle with any pending request is always followed by a broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_fill | input | 6 | Per-buffer fill strobe |
| ld_fill_data | input | 192 | Per-buffer fill data, buffer i in bits [32i+31:32i] |
| ld_busy | output | 6 | Buffer holds a result not yet broadcast |
| add_in_valid | input | 1 | Add issue request |
| add_in_tag | input | 4 | Tag of the issuing station |
| add_in_a | input | 32 | First addend |
| add_in_b | input | 32 | Second addend |
| add_in_ready | output | 1 | Adder accepts an issue this cycle |
| md_in_valid | input | 1 | Multiply/divide issue request |
| md_in_div | input | 1 | 1 selects divide, 0 selects multiply |
| md_in_tag | input | 4 | Tag of the issuing station |
| md_in_a | input | 32 | Multiplicand or dividend |
| md_in_b | input | 32 | Multiplier or divisor |
| md_in_ready | output | 1 | Multiply/divide unit accepts an issue |
| bus_valid | output | 1 | A broadcast is on the bus |
| bus_tag | output | 4 | Producer tag of the broadcast |
| bus_data | output | 32 | Result data of the broadcast |

## Verification
Each result has a fixed due time when uncontested, counted from the edge that accepted its input. A fill is due one edge later, an add two, a multiply three and a divide twelve. The bench reads the cycle counter at the first falling edge after acceptance and stamps each expected item with the counter value at which the bus should show it. The monitor compares stamps at falling edges. In contention scenarios the delays come from the priority order and are worked out ahead of time. In the starvation run only the order of broadcasts is checked.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int TAG_W = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LD   = 2'd1,
        SRC_MD   = 2'd2,
        SRC_ADD  = 2'd3
    } src_e;
endpackage

// File: rtl/rb_ldbuf.sv
module rb_ldbuf #(
    parameter int NUM_LD = 6,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LD-1:0]        fill,
    input  logic [NUM_LD*DATA_W-1:0] fill_data,
    input  logic                     gnt,
    output logic [NUM_LD-1:0]        busy,
    output logic                     req,
    output logic [TAG_W-1:0]         req_tag,
    output logic [DATA_W-1:0]        req_data
);
    localparam int IDX_W = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;

    typedef struct packed {
        logic [NUM_LD-1:0]             full;
        logic [NUM_LD-1:0][DATA_W-1:0] data;
    } ld_st_t;

    ld_st_t            st_d, st_q;
    logic [IDX_W-1:0]  sel;

    always_comb begin
        st_d = st_q;
        sel  = '0;
        for (int i = NUM_LD - 1; i >= 0; i--) begin
            if (st_q.full[i]) sel = IDX_W'(i);
        end
        if (gnt) st_d.full[sel] = 1'b0;
        for (int i = 0; i < NUM_LD; i++) begin
            if (fill[i] && !st_q.full[i]) begin
                st_d.full[i] = 1'b1;
                st_d.data[i] = fill_data[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.full;
    assign req      = |st_q.full;
    assign req_tag  = TAG_W'(sel) + TAG_W'(1);
    assign req_data = st_q.data[sel];

    for (genvar g = 0; g < NUM_LD; g++) begin : g_chk
        assert_fill_full_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (fill[g] && st_q.full[g]) |=> $stable(st_q.data[g]));
    end
endmodule

// File: rtl/rb_addpipe.sv
module rb_addpipe #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              in_ready,
    input  logic              gnt,
    output logic              req,
    output logic [TAG_W-1:0]  req_tag,
    output logic [DATA_W-1:0] req_data
);
    typedef struct packed {
        logic              s1_v;
        logic [TAG_W-1:0]  s1_tag;
        logic [DATA_W-1:0] s1_sum;
        logic              o_v;
        logic [TAG_W-1:0]  o_tag;
        logic [DATA_W-1:0] o_sum;
    } add_st_t;

    add_st_t st_d, st_q;
    logic    advance;

    always_comb begin
        st_d     = st_q;
        advance  = st_q.s1_v && (!st_q.o_v || gnt);
        in_ready = !st_q.s1_v || !st_q.o_v || gnt;
        if (advance) begin
            st_d.o_v   = 1'b1;
            st_d.o_tag = st_q.s1_tag;
            st_d.o_sum = st_q.s1_sum;
        end else if (gnt) begin
            st_d.o_v = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.s1_v   = 1'b1;
            st_d.s1_tag = in_tag;
            st_d.s1_sum = in_a + in_b;
        end else if (advance) begin
            st_d.s1_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req      = st_q.o_v;
    assign req_tag  = st_q.o_tag;
    assign req_data = st_q.o_sum;

    assert_add_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> (req && $stable(req_tag) && $stable(req_data)));
    assert_add_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && req && !gnt) |-> !in_ready);
endmodule

// File: rtl/rb_muldiv.sv
module rb_muldiv #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_div,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              in_ready,
    input  logic              gnt,
    output logic              req,
    output logic [TAG_W-1:0]  req_tag,
    output logic [DATA_W-1:0] req_data
);
    localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              busy;
        logic              is_div;
        logic [CNT_W-1:0]  cnt;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              o_v;
        logic [TAG_W-1:0]  o_tag;
        logic [DATA_W-1:0] o_res;
    } md_st_t;

    md_st_t            st_d, st_q;
    logic [DATA_W-1:0] result;

    always_comb begin
        if (st_q.is_div) result = (st_q.b == '0) ? '1 : st_q.a / st_q.b;
        else             result = st_q.a * st_q.b;
    end

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.busy && (!st_q.o_v || gnt);
        if (gnt) st_d.o_v = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy  = 1'b0;
                st_d.o_v   = 1'b1;
                st_d.o_tag = st_q.tag;
                st_d.o_res = result;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (in_valid && in_ready) begin
            st_d.busy   = 1'b1;
            st_d.is_div = in_div;
            st_d.tag    = in_tag;
            st_d.a      = in_a;
            st_d.b      = in_b;
            st_d.cnt    = in_div ? CNT_W'(DIV_LAT - 2) : CNT_W'(MUL_LAT - 2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req      = st_q.o_v;
    assign req_tag  = st_q.o_tag;
    assign req_data = st_q.o_res;

    assert_md_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !in_ready);
    assert_md_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> (req && $stable(req_tag) && $stable(req_data)));
endmodule

// File: rtl/rb_busarb.sv
module rb_busarb
    import rb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              md_req,
    input  logic [TAG_W-1:0]  md_tag,
    input  logic [DATA_W-1:0] md_data,
    input  logic              add_req,
    input  logic [TAG_W-1:0]  add_tag,
    input  logic [DATA_W-1:0] add_data,
    output logic              ld_gnt,
    output logic              md_gnt,
    output logic              add_gnt,
    output logic              bus_valid,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [DATA_W-1:0] bus_data
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bus_st_t;

    bus_st_t st_d, st_q;
    src_e    winner;

    always_comb begin
        if (ld_req)       winner = SRC_LD;
        else if (md_req)  winner = SRC_MD;
        else if (add_req) winner = SRC_ADD;
        else              winner = SRC_NONE;

        ld_gnt  = (winner == SRC_LD);
        md_gnt  = (winner == SRC_MD);
        add_gnt = (winner == SRC_ADD);

        st_d = '0;
        unique case (winner)
            SRC_LD:  st_d = '{valid: 1'b1, tag: ld_tag,  data: ld_data};
            SRC_MD:  st_d = '{valid: 1'b1, tag: md_tag,  data: md_data};
            SRC_ADD: st_d = '{valid: 1'b1, tag: add_tag, data: add_data};
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_valid = st_q.valid;
    assign bus_tag   = st_q.tag;
    assign bus_data  = st_q.data;

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_tag == '0 && bus_data == '0));
    assert_work_conserving_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req || md_req || add_req) |=> bus_valid);
    assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && (md_req || add_req)) |=> (bus_tag == $past(ld_tag) && bus_data == $past(ld_data)));
    assert_md_over_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && md_req && add_req) |=> (bus_tag == $past(md_tag)));
endmodule

// File: rtl/rb_top.sv
module rb_top #(
    parameter int NUM_LD  = 6,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 4,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LD-1:0]        ld_fill,
    input  logic [NUM_LD*DATA_W-1:0] ld_fill_data,
    output logic [NUM_LD-1:0]        ld_busy,
    input  logic                     add_in_valid,
    input  logic [TAG_W-1:0]         add_in_tag,
    input  logic [DATA_W-1:0]        add_in_a,
    input  logic [DATA_W-1:0]        add_in_b,
    output logic                     add_in_ready,
    input  logic                     md_in_valid,
    input  logic                     md_in_div,
    input  logic [TAG_W-1:0]         md_in_tag,
    input  logic [DATA_W-1:0]        md_in_a,
    input  logic [DATA_W-1:0]        md_in_b,
    output logic                     md_in_ready,
    output logic                     bus_valid,
    output logic [TAG_W-1:0]         bus_tag,
    output logic [DATA_W-1:0]        bus_data
);
    logic              ld_req, md_req, add_req;
    logic              ld_gnt, md_gnt, add_gnt;
    logic [TAG_W-1:0]  ld_tag, md_tag, add_tag;
    logic [DATA_W-1:0] ld_data, md_data, add_data;

    rb_ldbuf #(.NUM_LD(NUM_LD), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ld (
        .clk(clk), .rst_n(rst_n), .fill(ld_fill), .fill_data(ld_fill_data),
        .gnt(ld_gnt), .busy(ld_busy), .req(ld_req), .req_tag(ld_tag), .req_data(ld_data)
    );

    rb_addpipe #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_add (
        .clk(clk), .rst_n(rst_n), .in_valid(add_in_valid), .in_tag(add_in_tag),
        .in_a(add_in_a), .in_b(add_in_b), .in_ready(add_in_ready), .gnt(add_gnt),
        .req(add_req), .req_tag(add_tag), .req_data(add_data)
    );

    rb_muldiv #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_md (
        .clk(clk), .rst_n(rst_n), .in_valid(md_in_valid), .in_div(md_in_div),
        .in_tag(md_in_tag), .in_a(md_in_a), .in_b(md_in_b), .in_ready(md_in_ready),
        .gnt(md_gnt), .req(md_req), .req_tag(md_tag), .req_data(md_data)
    );

    rb_busarb #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .ld_req(ld_req), .ld_tag(ld_tag), .ld_data(ld_data),
        .md_req(md_req), .md_tag(md_tag), .md_data(md_data),
        .add_req(add_req), .add_tag(add_tag), .add_data(add_data),
        .ld_gnt(ld_gnt), .md_gnt(md_gnt), .add_gnt(add_gnt),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );
endmodule

// File: tb/rb_top_tb.sv
module rb_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   ld_fill = '0;
    logic [191:0] ld_fill_data = '0;
    logic [5:0]   ld_busy;
    logic         add_in_valid = 1'b0;
    logic [3:0]   add_in_tag = '0;
    logic [31:0]  add_in_a = '0, add_in_b = '0;
    logic         add_in_ready;
    logic         md_in_valid = 1'b0, md_in_div = 1'b0;
    logic [3:0]   md_in_tag = '0;
    logic [31:0]  md_in_a = '0, md_in_b = '0;
    logic         md_in_ready;
    logic         bus_valid;
    logic [3:0]   bus_tag;
    logic [31:0]  bus_data;

    typedef struct {
        logic [3:0]  tag;
        logic [31:0] data;
        int          due;
        string       rq;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rb_top u_dut (
        .clk(clk), .rst_n(rst_n), .ld_fill(ld_fill), .ld_fill_data(ld_fill_data),
        .ld_busy(ld_busy), .add_in_valid(add_in_valid), .add_in_tag(add_in_tag),
        .add_in_a(add_in_a), .add_in_b(add_in_b), .add_in_ready(add_in_ready),
        .md_in_valid(md_in_valid), .md_in_div(md_in_div), .md_in_tag(md_in_tag),
        .md_in_a(md_in_a), .md_in_b(md_in_b), .md_in_ready(md_in_ready),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic expect_item(input logic [3:0] t, input logic [31:0] d, input int due,
                               input string rq);
        exp_t e;
        e.tag = t; e.data = d; e.due = due; e.rq = rq;
        q.push_back(e);
    endtask

    // Monitor: compares every broadcast against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && bus_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7", "unexpected broadcast tag", longint'(bus_tag), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(bus_tag == e.tag, e.rq, "bus_tag", longint'(bus_tag), longint'(e.tag));
                chk(bus_data == e.data, e.rq, "bus_data", longint'(bus_data), longint'(e.data));
                if (e.due >= 0) chk(cyc == e.due, e.rq, "broadcast cycle", longint'(cyc), longint'(e.due));
            end
        end
    end

    // Drivers: called at a falling edge, return at the falling edge after acceptance.
    task automatic issue_add(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b,
                             input bit push);
        while (!add_in_ready) @(negedge clk);
        add_in_valid = 1'b1; add_in_tag = t; add_in_a = a; add_in_b = b;
        @(negedge clk);
        add_in_valid = 1'b0;
        if (push) expect_item(t, a + b, cyc + 2, "R3");
    endtask

    task automatic issue_md(input bit div, input logic [3:0] t, input logic [31:0] a,
                            input logic [31:0] b, input bit push);
        logic [31:0] r;
        while (!md_in_ready) @(negedge clk);
        md_in_valid = 1'b1; md_in_div = div; md_in_tag = t; md_in_a = a; md_in_b = b;
        @(negedge clk);
        md_in_valid = 1'b0;
        if (div) r = (b == 0) ? 32'hFFFF_FFFF : a / b;
        else     r = a * b;
        if (push) expect_item(t, r, cyc + (div ? 12 : 3), div ? "R5" : "R4");
    endtask

    task automatic fill_one(input int idx, input logic [31:0] d, input bit push);
        ld_fill[idx] = 1'b1;
        ld_fill_data[idx*32 +: 32] = d;
        @(negedge clk);
        ld_fill = '0;
        if (push) expect_item(4'(idx + 1), d, cyc + 1, "R2");
    endtask

    task automatic drain();
        int n = 0;
        while (q.size() != 0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_valid == 0, "R1", "bus_valid in reset", bus_valid, 0);
        chk(bus_tag == 0, "R1", "bus_tag in reset", bus_tag, 0);
        chk(ld_busy == 0, "R1", "ld_busy in reset", ld_busy, 0);
        chk(add_in_ready == 1 && md_in_ready == 1, "R1", "ready in reset",
            {add_in_ready, md_in_ready}, 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 idle bus
        chk(bus_valid == 0 && bus_tag == 0 && bus_data == 0, "R9", "idle bus",
            {bus_valid, bus_tag, bus_data}, 0);

        // Uncontested latencies
        fill_one(3, 32'hDEAD_0003, 1'b1);
        drain();
        issue_add(4'd7, 32'h1234_5678, 32'hF000_0001, 1'b1);
        drain();
        issue_add(4'd8, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1);
        drain();
        issue_md(1'b0, 4'd10, 32'h0001_0003, 32'h0002_0005, 1'b1);
        @(negedge clk);
        chk(md_in_ready == 0, "R8", "md ready during multiply", md_in_ready, 0);
        drain();
        issue_md(1'b1, 4'd11, 32'd1000, 32'd7, 1'b1);
        chk(md_in_ready == 0, "R8", "md ready during divide", md_in_ready, 0);
        repeat (5) @(negedge clk);
        chk(md_in_ready == 0, "R8", "md ready mid divide", md_in_ready, 0);
        drain();
        issue_md(1'b1, 4'd11, 32'd55, 32'd0, 1'b1);
        drain();

        // R2 lowest index first, R10 fill of a full buffer ignored
        ld_fill = 6'b010010;
        ld_fill_data[4*32 +: 32] = 32'hAAAA_0004;
        ld_fill_data[1*32 +: 32] = 32'hAAAA_0001;
        @(negedge clk);
        a0 = cyc;
        expect_item(4'd2, 32'hAAAA_0001, a0 + 1, "R2");
        expect_item(4'd5, 32'hAAAA_0004, a0 + 2, "R10");
        ld_fill = 6'b010000;
        ld_fill_data[4*32 +: 32] = 32'hBBBB_0004;
        @(negedge clk);
        ld_fill = '0;
        drain();
        chk(ld_busy == 0, "R10", "ld_busy after ignored fill", ld_busy, 0);

        // R6/R7 contention: load, multiply and add collide
        add_in_valid = 1'b1; add_in_tag = 4'd9; add_in_a = 32'd40; add_in_b = 32'd2;
        md_in_valid = 1'b1; md_in_div = 1'b0; md_in_tag = 4'd12; md_in_a = 32'd6; md_in_b = 32'd7;
        @(negedge clk);
        a0 = cyc;
        add_in_valid = 1'b0; md_in_valid = 1'b0;
        expect_item(4'd1, 32'hC0DE_0000, a0 + 2, "R6");
        expect_item(4'd12, 32'd42, a0 + 3, "R6");
        expect_item(4'd9, 32'd42, a0 + 4, "R7");
        ld_fill[0] = 1'b1; ld_fill_data[0 +: 32] = 32'hC0DE_0000;
        @(negedge clk);
        ld_fill = '0;
        drain();

        // R8/R7 adder starved by a full load group
        for (int i = 0; i < 6; i++) begin
            ld_fill_data[i*32 +: 32] = 32'h5000_0000 + 32'(i);
            expect_item(4'(i + 1), 32'h5000_0000 + 32'(i), -1, "R6");
        end
        expect_item(4'd7, 32'd3, -1, "R7");
        expect_item(4'd8, 32'd5, -1, "R7");
        expect_item(4'd9, 32'd7, -1, "R7");
        ld_fill = 6'b111111;
        add_in_valid = 1'b1; add_in_tag = 4'd7; add_in_a = 32'd1; add_in_b = 32'd2;
        @(negedge clk);
        ld_fill = '0;
        add_in_tag = 4'd8; add_in_a = 32'd2; add_in_b = 32'd3;
        @(negedge clk);
        add_in_valid = 1'b0;
        chk(add_in_ready == 0, "R8", "adder ready with both stages held", add_in_ready, 0);
        chk(ld_busy != 0, "R11", "load group still pending", ld_busy, 1);
        issue_add(4'd9, 32'd3, 32'd4, 1'b0);
        drain();

        chk(q.size() == 0, "R11", "scoreboard empty at end", q.size(), 0);
        chk(bus_valid == 0 && bus_tag == 0, "R9", "idle bus at end", {bus_valid, bus_tag}, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule